// File: doc/BRIEF.md
# Nibble-Stream Frame Check Sequence Appender

This block sits on the transmit side of a 4-bit-wide Ethernet datapath. It takes a frame (destination address, source address, length/type and payload) as a stream of nibbles, one per clock while the input valid is high. Each nibble is forwarded unchanged, one cycle later. While the nibbles pass through, a 32-bit remainder is updated from each nibble by a combinational next-remainder function. That function is the standard CRC-32 generator unrolled four bits deep.

When the input marks the last nibble, the block turns the final remainder into the frame check sequence. It complements the remainder and then reverses its bit order. The result goes out as eight more nibbles on the same output stream, and the output last flag sits on the eighth. A nibble datapath runs at a quarter of the line bit rate, which is twice the byte rate. Frames may have any length, and idle cycles inside a frame are allowed.

Top module: `fcs_nibble_appender`

## Requirements
- R1: While reset is asserted, and after it is released with no input, out_valid and out_last are low.
- R2: Every nibble accepted with in_valid high appears on out_data one cycle later, with out_valid high and out_last low.
- R3: After a nibble accepted with in_last high, the eight following cycles each present one FCS nibble with out_valid high. These eight cycles follow directly after the forwarded last nibble. in_valid must stay low during them.
- R4: The FCS is computed as follows:
  - The remainder uses the generator polynomial 0x04C11DB7, shifting toward the MSB, with each new bit XORed into bit 31.
  - Within a nibble, bit 0 is taken first.
  - FCS = bit-reverse(~remainder). FCS nibble k, for k = 0 to 7 with k = 0 sent first, carries FCS bits [4k+3:4k].
- R5: out_last is high only on the eighth FCS nibble, for exactly one cycle.
- R6: The remainder is preset to all ones at reset and again at the first nibble after a last nibble. Frames sent back to back therefore get independent FCS values. This still holds when reset cuts a tail short.
- R7: When the same remainder is run over a frame and then its eight FCS nibbles, it ends at the residue 0xC704DD7B.
- R8: Any frame length works, from a single nibble up to 72 nibbles and beyond.
- R9: A cycle with in_valid low inside a frame produces out_valid low and leaves the remainder unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_data | input | 4 | Frame nibble, bit 0 first on the wire |
| in_valid | input | 1 | in_data carries a frame nibble this cycle |
| in_last | input | 1 | Marks the final frame nibble, qualified by in_valid |
| out_data | output | 4 | Forwarded nibble or FCS nibble |
| out_valid | output | 1 | out_data is meaningful this cycle |
| out_last | output | 1 | High on the final FCS nibble |

## Verification
A forwarded nibble is due one cycle after the edge that accepts it. FCS nibble k is due k+2 cycles after the edge that accepts the last frame nibble, and out_last arrives with FCS nibble 7. The bench drives one input per cycle on the falling edge. It compares the outputs at the next falling edge against the value that same cycle's input should produce, so every result is taken in exactly the cycle it is due. Expected FCS values come from a bit-serial model. The captured FCS nibbles are fed back through that model to confirm the fixed residue.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int          CRC_W    = 32;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  // one serial step: data bit enters at the MSB end, feedback folds the polynomial
  function automatic logic [CRC_W-1:0] crc_bit_step(input logic [CRC_W-1:0] rem,
                                                     input logic d);
    logic fb;
    fb = rem[CRC_W-1] ^ d;
    return {rem[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  function automatic logic [CRC_W-1:0] bit_rev(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/fcs_rst_sync.sv
module fcs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/fcs_crc_update.sv
module fcs_crc_update #(
  parameter int DW = 4
) (
  input  logic [fcs_pkg::CRC_W-1:0] rem_i,
  input  logic [DW-1:0]             data_i,
  output logic [fcs_pkg::CRC_W-1:0] rem_o
);
  logic [fcs_pkg::CRC_W-1:0] chain [DW+1];

  assign chain[0] = rem_i;

  // unrolled serial chain, lowest data bit first
  genvar g;
  for (g = 0; g < DW; g++) begin : g_stage
    assign chain[g+1] = fcs_pkg::crc_bit_step(chain[g], data_i[g]);
  end

  assign rem_o = chain[DW];
endmodule

// File: rtl/fcs_crc_accum.sv
module fcs_crc_accum #(
  parameter int DW = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_en,
  input  logic                      acc_last,
  input  logic [DW-1:0]             acc_data,
  output logic [fcs_pkg::CRC_W-1:0] fcs_o
);
  localparam int CW = fcs_pkg::CRC_W;

  logic [CW-1:0] rem_q, rem_d, base, rem_next;
  logic          open_q, open_d;

  assign base = open_q ? rem_q : fcs_pkg::CRC_SEED;

  fcs_crc_update #(.DW(DW)) u_upd (
    .rem_i  (base),
    .data_i (acc_data),
    .rem_o  (rem_next)
  );

  assign fcs_o = fcs_pkg::bit_rev(~rem_next);

  always_comb begin
    rem_d  = rem_q;
    open_d = open_q;
    if (acc_en) begin
      rem_d  = rem_next;
      open_d = !acc_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= fcs_pkg::CRC_SEED;
      open_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      open_q <= open_d;
    end
  end

  // R9: an idle cycle leaves the remainder untouched
  a_r9_rem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> (rem_q == $past(rem_q)));
endmodule

// File: rtl/fcs_tail_gen.sv
module fcs_tail_gen #(
  parameter int DW = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [fcs_pkg::CRC_W-1:0] fcs_i,
  output logic                      tail_valid,
  output logic [DW-1:0]             tail_data,
  output logic                      tail_last
);
  localparam int CW    = fcs_pkg::CRC_W;
  localparam int NIB   = CW / DW;
  localparam int CNT_W = $clog2(NIB + 1);

  logic [CW-1:0]    sr_q, sr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sr_en;

  assign tail_valid = (cnt_q != '0);
  assign tail_data  = sr_q[DW-1:0];
  assign tail_last  = (cnt_q == CNT_W'(1));

  always_comb begin
    sr_en = 1'b0;
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (start) begin
      sr_en = 1'b1;
      sr_d  = fcs_i;
      cnt_d = CNT_W'(NIB);
    end else if (tail_valid) begin
      sr_en = 1'b1;
      sr_d  = sr_q >> DW;
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

  // R3: a tail begins on the cycle after the last frame nibble
  a_r3_tail_starts: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (tail_valid && !tail_last));
  // R5: the final-nibble flag is a single pulse that ends the tail
  a_r5_last_ends_tail: assert property (@(posedge clk) disable iff (!rst_n)
    tail_last |=> !tail_valid);
endmodule

// File: rtl/fcs_out_stage.sv
module fcs_out_stage #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd_valid,
  input  logic [DW-1:0] fwd_data,
  input  logic          tail_valid,
  input  logic [DW-1:0] tail_data,
  input  logic          tail_last,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last
);
  logic          v_d, l_d, d_en;
  logic [DW-1:0] d_d;

  always_comb begin
    v_d  = 1'b0;
    l_d  = 1'b0;
    d_en = 1'b0;
    d_d  = out_data;
    if (tail_valid) begin
      v_d  = 1'b1;
      l_d  = tail_last;
      d_en = 1'b1;
      d_d  = tail_data;
    end else if (fwd_valid) begin
      v_d  = 1'b1;
      d_en = 1'b1;
      d_d  = fwd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= v_d;
      out_last  <= l_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
    end else if (d_en) begin
      out_data <= d_d;
    end
  end
endmodule

// File: rtl/fcs_nibble_appender.sv
module fcs_nibble_appender #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  input  logic          in_last,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          out_last
);
  logic                      rst_i_n;
  logic                      accept, start;
  logic [fcs_pkg::CRC_W-1:0] fcs;
  logic                      t_valid, t_last;
  logic [DW-1:0]             t_data;

  fcs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign accept = in_valid && !t_valid;
  assign start  = accept && in_last;

  fcs_crc_accum #(.DW(DW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .acc_en   (accept),
    .acc_last (in_last),
    .acc_data (in_data),
    .fcs_o    (fcs)
  );

  fcs_tail_gen #(.DW(DW)) u_tail (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .start      (start),
    .fcs_i      (fcs),
    .tail_valid (t_valid),
    .tail_data  (t_data),
    .tail_last  (t_last)
  );

  fcs_out_stage #(.DW(DW)) u_out (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .fwd_valid  (accept),
    .fwd_data   (in_data),
    .tail_valid (t_valid),
    .tail_data  (t_data),
    .tail_last  (t_last),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_last   (out_last)
  );

  // R1: nothing is driven out while the block is held in reset
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_i_n |-> (!out_valid && !out_last));
  // R2: an accepted nibble shows up one cycle later, unchanged
  a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_i_n)
    accept |=> (out_valid && !out_last && out_data == $past(in_data)));
  // R3: the sender keeps in_valid low while the FCS tail drains
  a_r3_no_input_in_tail: assert property (@(posedge clk) disable iff (!rst_i_n)
    t_valid |-> !in_valid);
  // R5: out_last only ever qualifies a valid nibble
  a_r5_last_is_valid: assert property (@(posedge clk) disable iff (!rst_i_n)
    out_last |-> out_valid);
  // R9: no input and no tail means an idle output
  a_r9_idle_gap: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!in_valid && !t_valid) |=> !out_valid);
endmodule

// File: tb/fcs_nibble_appender_tb_top.sv
module fcs_nibble_appender_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] in_data;
  logic       in_valid, in_last;
  logic [3:0] out_data;
  logic       out_valid, out_last;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  logic done = 1'b0;

  logic [3:0] fr  [0:255];
  logic [3:0] obs [0:7];

  always #5 clk = ~clk;

  fcs_nibble_appender #(.DW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .out_data(out_data), .out_valid(out_valid),
    .out_last(out_last)
  );

  // bit-serial reference: bit 0 of each nibble first, feedback into bit 31
  function automatic logic [31:0] ser_nib(input logic [31:0] c, input logic [3:0] d);
    for (int i = 0; i < 4; i++) begin
      logic fb;
      fb = c[31] ^ d[i];
      c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
    end
    return c;
  endfunction

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  task automatic check(input string req, input logic ev, input logic [3:0] ed,
                       input logic el);
    n_cmp++;
    if (out_valid !== ev || out_last !== el || (ev && out_data !== ed)) begin
      n_bad++;
      $display("FAIL %s: got v=%b d=%h l=%b, expected v=%b d=%h l=%b",
               req, out_valid, out_data, out_last, ev, ed, el);
    end
  endtask

  // called at a falling edge: drive, wait one cycle, compare at next falling edge
  task automatic step(input logic v, input logic [3:0] d, input logic l,
                      input logic ev, input logic [3:0] ed, input logic el,
                      input string req);
    in_valid = v; in_data = d; in_last = l;
    @(negedge clk);
    check(req, ev, ed, el);
  endtask

  task automatic fill(input int len, input int mode, input int seed);
    logic [15:0] lf;
    lf = 16'hACE1 ^ 16'(seed);
    for (int i = 0; i < len; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (mode)
        0: fr[i] = lf[3:0];
        1: fr[i] = 4'(i);
        2: fr[i] = 4'h0;
        default: fr[i] = 4'hF;
      endcase
    end
  endtask

  // R2 R3 R4 R5 R7 R8 R9; abort_at < 8 asserts reset after that many tail cycles
  task automatic send_frame(input int len, input int gap, input int abort_at);
    logic [31:0] rem, fcs;
    rem = 32'hFFFF_FFFF;
    for (int i = 0; i < len; i++) rem = ser_nib(rem, fr[i]);
    fcs = rev32(~rem);
    for (int i = 0; i < len; i++) begin
      step(1'b1, fr[i], (i == len-1), 1'b1, fr[i], 1'b0, "R2 forward");
      if (gap != 0 && i != len-1 && (i % gap) == gap-1)
        step(1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, "R9 idle gap");
    end
    for (int k = 0; k < 8; k++) begin
      if (k == abort_at) begin
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-tail", 1'b0, 4'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 after release", 1'b0, 4'h0, 1'b0);
        return;
      end
      in_valid = 1'b0; in_last = 1'b0;
      @(negedge clk);
      obs[k] = out_data;
      check((k == 7) ? "R5 final FCS nibble" : "R3 R4 FCS nibble",
            1'b1, fcs[4*k +: 4], (k == 7));
    end
    rem = 32'hFFFF_FFFF;
    for (int i = 0; i < len; i++) rem = ser_nib(rem, fr[i]);
    for (int k = 0; k < 8; k++) rem = ser_nib(rem, obs[k]);
    n_cmp++;
    if (rem !== 32'hC704DD7B) begin
      n_bad++;
      $display("FAIL R7 residue len=%0d: got %h expected c704dd7b", len, rem);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = 4'h0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, 4'h0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", 1'b0, 4'h0, 1'b0);

    // R8 sweep over lengths 1..40, data patterns and gap spacings
    for (int len = 1; len <= 40; len++) begin
      fill(len, len % 4, len);
      send_frame(len, (len % 3 == 0) ? 2 : 0, 8);
    end
    // R8 long frames, back to back (R6 reseed between them)
    foreach (fr[i]) fr[i] = 4'h0;
    fill(72, 0, 7);   send_frame(72, 0, 8);
    fill(73, 1, 9);   send_frame(73, 5, 8);
    fill(128, 0, 3);  send_frame(128, 0, 8);
    fill(255, 0, 11); send_frame(255, 7, 8);
    // R6 reset cutting a tail short, then a clean frame
    fill(20, 0, 21); send_frame(20, 0, 3);
    fill(20, 0, 22); send_frame(20, 0, 8);
    // R6 one-nibble frames back to back
    for (int v = 0; v < 16; v++) begin
      fr[0] = 4'(v);
      send_frame(1, 0, 8);
    end
    step(1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, "R9 idle end");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule